// File: doc/BRIEF.md
# Keyed Write Protection Gate

This block sits between a register bus write port and a register file. It keeps a small set of configuration registers from being changed unless software has first written a two-byte unlock code into a dedicated key register. The code must arrive in order: first 0xCA, then 0x53, both written to the key register. Writes to other addresses may come between the two bytes.

Once the code is complete, writes to the guarded registers pass through to the register file. They keep passing until the key register is written again. Writing 0xFF, or any other value, closes the gate. A wrong byte in the middle of the sequence also drops the gate back to locked, and software then has to start again from the first byte. Registers outside the guarded set are never held back. Writes to the key register are used up by the gate and are never passed on.

The write port follows valid/ready rules. A transfer happens in any cycle where `wr_valid_i` and `wr_ready_o` are both high. The master must hold address and data steady while valid is high and ready is low. Back-pressure comes only from the register file, through `rf_ready_i`. Key-register writes and dropped guarded writes complete at once, whatever `rf_ready_i` is doing. The gate state can be observed on `unlocked_o`.

Top module: `wp_guard`

## Requirements
- R1: After reset the gate is locked and `unlocked_o` is 0.
- R2: A key-register write (address 0x24) whose low byte is 0xCA, followed by a later key-register write whose low byte is 0x53, sets `unlocked_o` to 1 in the cycle after the second transfer. Writes to other addresses between the two bytes do not break the sequence.
- R3: Only bits [7:0] of a key-register write are compared; the upper data bits have no effect.
- R4: While the gate is not unlocked, a write to a guarded address (0x18 or 0x20) is accepted (`wr_ready_o`=1) but `rf_we_o` stays 0.
- R5: While unlocked, a write to a guarded address asserts `rf_we_o` in the same cycle, with `rf_addr_o`/`rf_data_o` equal to the bus address and data.
- R6: While unlocked, any key-register write relocks the gate, including the lock value 0xFF. `unlocked_o` returns to 0 in the next cycle.
- R7: A key-register write with a low byte other than the expected next key returns the gate to locked. This covers 0x53 sent first and a wrong byte after 0xCA. A fresh 0xCA is then needed before 0x53 has any effect.
- R8: Writes to addresses that are neither guarded nor the key register reach the register file in every gate state.
- R9: Key-register writes never assert `rf_we_o` and are always accepted, even when `rf_ready_i` is 0.
- R10: For writes that go to the register file, `wr_ready_o` equals `rf_ready_i`, and `rf_we_o` is high only in a cycle where `wr_valid_i` and `rf_ready_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Bus write request valid |
| wr_ready_o | output | 1 | Bus write accepted this cycle |
| wr_addr_i | input | ADDR_W | Bus write byte address |
| wr_data_i | input | DATA_W | Bus write data |
| rf_we_o | output | 1 | Register file write enable |
| rf_ready_i | input | 1 | Register file can take a write |
| rf_addr_o | output | ADDR_W | Register file write address |
| rf_data_o | output | DATA_W | Register file write data |
| unlocked_o | output | 1 | Gate is open for guarded writes |

## Verification
The assertions assume that the bus master keeps address and data stable while a request is stalled. They also assume that addresses are whole-register byte offsets, so that each guarded register has exactly one address that maps to it. The bench drives one write at a time. Each write is set up on the falling edge, held through one rising edge and then withdrawn. The bench only lowers `rf_ready_i` in a scenario that checks back-pressure, and it never changes a request while that request is stalled.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT-1:0][ADDR_W-1:0] PROT_ADDRS = '{8'h20, 8'h18},
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_prot_o,
  output logic              is_key_o
);
  logic [NUM_PROT-1:0] hit;

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_cmp
    assign hit[g] = (addr_i == PROT_ADDRS[g]);
  end

  assign is_prot_o = |hit;
  assign is_key_o  = (addr_i == KEY_ADDR);
endmodule

// File: rtl/wp_key_fsm.sv
module wp_key_fsm
  import wp_pkg::*;
#(
  parameter int         KEY_W  = 8,
  parameter logic [7:0] KEY_A  = 8'hCA,
  parameter logic [7:0] KEY_B  = 8'h53,
  parameter logic [7:0] LOCK_V = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_byte_i,
  output logic             open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      unique case (state_q)
        KS_LOCKED: state_d = (key_byte_i == KEY_A) ? KS_ARMED : KS_LOCKED;
        KS_ARMED:  state_d = (key_byte_i == KEY_B) ? KS_OPEN  : KS_LOCKED;
        KS_OPEN:   state_d = KS_LOCKED;
        default:   state_d = KS_LOCKED;
      endcase
      if (key_byte_i == LOCK_V) state_d = KS_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              valid_i,
  input  logic              is_prot_i,
  input  logic              is_key_i,
  input  logic              open_i,
  input  logic              rf_ready_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              key_wr_o,
  output logic              rf_we_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o
);
  logic dropped;
  logic to_rf;

  assign dropped   = is_prot_i && !open_i;
  assign to_rf     = !is_key_i && !dropped;
  assign ready_o   = is_key_i || dropped || rf_ready_i;
  assign key_wr_o  = valid_i && is_key_i;
  assign rf_we_o   = valid_i && to_rf && rf_ready_i;
  assign rf_addr_o = addr_i;
  assign rf_data_o = data_i;
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT-1:0][ADDR_W-1:0] PROT_ADDRS = '{8'h20, 8'h18},
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24,
  parameter logic [7:0] KEY_A  = 8'hCA,
  parameter logic [7:0] KEY_B  = 8'h53,
  parameter logic [7:0] LOCK_V = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rf_we_o,
  input  logic              rf_ready_i,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              unlocked_o
);
  localparam int KEY_W = 8;

  logic is_prot, is_key, key_wr, open;

  wp_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
    .PROT_ADDRS(PROT_ADDRS), .KEY_ADDR(KEY_ADDR)
  ) i_dec (
    .addr_i(wr_addr_i), .is_prot_o(is_prot), .is_key_o(is_key)
  );

  wp_key_fsm #(
    .KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .LOCK_V(LOCK_V)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .key_wr_i(key_wr),
    .key_byte_i(wr_data_i[KEY_W-1:0]), .open_o(open)
  );

  wp_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_gate (
    .valid_i(wr_valid_i), .is_prot_i(is_prot), .is_key_i(is_key),
    .open_i(open), .rf_ready_i(rf_ready_i), .addr_i(wr_addr_i),
    .data_i(wr_data_i), .ready_o(wr_ready_o), .key_wr_o(key_wr),
    .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o), .rf_data_o(rf_data_o)
  );

  assign unlocked_o = open;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT-1:0][ADDR_W-1:0] PROT_ADDRS = '{8'h20, 8'h18},
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24,
  parameter logic [7:0] KEY_B = 8'h53
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rf_we_o,
  input logic              rf_ready_i,
  input logic              unlocked_o
);
  logic guarded, key_xfer;

  always_comb begin
    guarded = 1'b0;
    for (int i = 0; i < NUM_PROT; i++)
      if (wr_addr_i == PROT_ADDRS[i]) guarded = 1'b1;
  end

  assign key_xfer = wr_valid_i && (wr_addr_i == KEY_ADDR);

  AST_OPEN_NEEDS_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(key_xfer && wr_data_i[7:0] == KEY_B)); // R2

  AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && guarded && !unlocked_o) |-> (!rf_we_o && wr_ready_o)); // R4

  AST_OPEN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && guarded && unlocked_o && rf_ready_i) |-> rf_we_o); // R5

  AST_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_xfer && unlocked_o) |=> !unlocked_o); // R6

  AST_FREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !guarded && wr_addr_i != KEY_ADDR && rf_ready_i) |-> rf_we_o); // R8

  AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    key_xfer |-> (!rf_we_o && wr_ready_o)); // R9

  AST_WE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (wr_valid_i && rf_ready_i)); // R10
endmodule

bind wp_guard wp_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
  .PROT_ADDRS(PROT_ADDRS), .KEY_ADDR(KEY_ADDR), .KEY_B(KEY_B)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rf_we_o(rf_we_o),
  .rf_ready_i(rf_ready_i), .unlocked_o(unlocked_o)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic        wr_ready_o;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rf_we_o;
  logic        rf_ready_i = 1'b1;
  logic [7:0]  rf_addr_o;
  logic [31:0] rf_data_o;
  logic        unlocked_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [7:0] A_KEY = 8'h24, A_CTL = 8'h18, A_SEC = 8'h20, A_FREE = 8'h5C;

  always #5 clk = ~clk;

  wp_guard i_wp_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rf_we_o(rf_we_o),
    .rf_ready_i(rf_ready_i), .rf_addr_o(rf_addr_o), .rf_data_o(rf_data_o),
    .unlocked_o(unlocked_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write: drive at negedge, sample combinational outputs, cross one rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    output logic we, output logic rdy);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    #2;
    we = rf_we_o; rdy = wr_ready_o;
    @(posedge clk);
    #1;
    wr_valid_i = 1'b0;
  endtask

  task automatic key(input logic [31:0] d);
    logic we, rdy;
    wr(A_KEY, d, we, rdy);
    check("R9 key write not forwarded", {31'd0, we}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 locked after reset", {31'd0, unlocked_o}, 32'd0);
    check("R1 no write after reset", {31'd0, rf_we_o}, 32'd0);
  endtask

  task automatic t_locked_drop;
    logic we, rdy;
    wr(A_CTL, 32'h1111, we, rdy);
    check("R4 guarded ctl dropped", {31'd0, we}, 32'd0);
    check("R4 dropped write accepted", {31'd0, rdy}, 32'd1);
    wr(A_SEC, 32'h2222, we, rdy);
    check("R4 guarded sec dropped", {31'd0, we}, 32'd0);
  endtask

  task automatic t_free;
    logic we, rdy;
    wr(A_FREE, 32'h3333, we, rdy);
    check("R8 free address passes while locked", {31'd0, we}, 32'd1);
  endtask

  task automatic t_unlock;
    logic we, rdy;
    logic [7:0] ra;
    logic [31:0] rd;
    key(32'hCA);
    check("R4 armed not open", {31'd0, unlocked_o}, 32'd0);
    wr(A_FREE, 32'h44, we, rdy);   // between the two bytes
    key(32'h53);
    check("R2 unlocked after sequence", {31'd0, unlocked_o}, 32'd1);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = A_CTL; wr_data_i = 32'hDEAD_BEEF;
    #2;
    we = rf_we_o; ra = rf_addr_o; rd = rf_data_o;
    @(posedge clk); #1; wr_valid_i = 1'b0;
    check("R5 guarded write passes", {31'd0, we}, 32'd1);
    check("R5 address forwarded", {24'd0, ra}, {24'd0, A_CTL});
    check("R5 data forwarded", rd, 32'hDEAD_BEEF);
    wr(A_FREE, 32'h55, we, rdy);
    check("R8 free address passes while open", {31'd0, we}, 32'd1);
  endtask

  task automatic t_lockval;
    logic we, rdy;
    key(32'hFF);
    check("R6 lock value relocks", {31'd0, unlocked_o}, 32'd0);
    wr(A_SEC, 32'h66, we, rdy);
    check("R6 guarded dropped after relock", {31'd0, we}, 32'd0);
  endtask

  task automatic t_other_relock;
    key(32'hCA); key(32'h53);
    check("R2 reopened", {31'd0, unlocked_o}, 32'd1);
    key(32'hCA);
    check("R6 any key write relocks", {31'd0, unlocked_o}, 32'd0);
    key(32'h53);
    check("R6 no reopen without fresh first key", {31'd0, unlocked_o}, 32'd0);
  endtask

  task automatic t_wrong_order;
    key(32'h53);
    check("R7 second key first stays locked", {31'd0, unlocked_o}, 32'd0);
    key(32'hCA); key(32'h12);
    check("R7 wrong byte after first key", {31'd0, unlocked_o}, 32'd0);
    key(32'h53);
    check("R7 restart required", {31'd0, unlocked_o}, 32'd0);
  endtask

  task automatic t_high_bits;
    key(32'hABCD_12CA); key(32'h0000_7753);
    check("R3 upper bits ignored", {31'd0, unlocked_o}, 32'd1);
    key(32'h5500_00FF);
    check("R3 lock byte with upper bits", {31'd0, unlocked_o}, 32'd0);
  endtask

  task automatic t_backpressure;
    logic we, rdy;
    rf_ready_i = 1'b0;
    wr(A_FREE, 32'h77, we, rdy);
    check("R10 stalled write no enable", {31'd0, we}, 32'd0);
    check("R10 ready follows register file", {31'd0, rdy}, 32'd0);
    wr(A_KEY, 32'hCA, we, rdy);
    check("R9 key accepted under stall", {31'd0, rdy}, 32'd1);
    wr(A_KEY, 32'h53, we, rdy);
    check("R2 unlock under stall", {31'd0, unlocked_o}, 32'd1);
    wr(A_CTL, 32'h88, we, rdy);
    check("R10 open guarded write stalls", {31'd0, rdy}, 32'd0);
    rf_ready_i = 1'b1;
    wr(A_CTL, 32'h88, we, rdy);
    check("R10 write completes when ready", {31'd0, we & rdy}, 32'd1);
    key(32'hFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    t_reset();
    t_locked_drop();
    t_free();
    t_unlock();
    t_lockval();
    t_other_relock();
    t_wrong_order();
    t_high_bits();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule